// File: doc/BRIEF.md
# Latched Bus Chip-Select Decoder

This block sits on the local bus of a 32-bit graphics processor whose address and data share one set of wires. During the address phase the processor raises an address-latch-enable; the block captures the three most significant address bits and address bits 2 and 3 in latches that pass the bus through while that enable is high and hold their contents once it falls. All region decoding works from the latched view, so the data that later occupies the same wires cannot disturb any select.

From the three top bits the block picks the memory section. It drives four active-low strobes: a non-volatile RAM select for the 0x60000000 section, a select for the top section (0xE0000000 upward, home of the program ROM at 0xFC000000 and of the reset vector), a program ROM output enable that also waits for the processor's row-address strobe and its transfer/output-enable strobe, and a second ROM-area select that adds one more qualifier. The top-section strobes are suppressed when address bit 2 is 1 and bit 3 is 0. Reset drives every strobe high at once and releases them synchronously.

Top module: `bus_cs_decoder`

## Requirements
- R1: While `ale` is high the latched view follows `bus_ad` in the same cycle, so the strobes reflect the address currently on the bus.
- R2: While `ale` is low the latched view holds the value present at the last rising clock edge on which `ale` was high; any change of `bus_ad` then leaves all four strobes unchanged.
- R3: `nvram_cs_n` is 0 exactly when latched bits 31,30,29 are 0,1,1, whatever the strobe and qualifier inputs are.
- R4: `high_cs_n` is 0 exactly when latched bits 31,30,29 are 1,1,1 and it is not the case that latched bit 2 is 1 and latched bit 3 is 0; strobes and qualifiers have no effect on it.
- R5: `rom_oe_n` is 0 exactly when the `high_cs_n` conditions hold, `ras_n` is 0, `trqe_n` is 0 and `qual_en` is 1.
- R6: `rom_oe_n` is 1 in every cycle in which `trqe_n` is 1, for any address.
- R7: `rom2_cs_n` is 0 exactly when the `rom_oe_n` conditions hold and `qual_aux` is 1.
- R8: Sections other than 0,1,1 and 1,1,1 in bits 31,30,29 assert none of the four strobes.
- R9: While `rst_n` is 0 all four strobes are 1; after `rst_n` rises they stay 1 until the second rising clock edge, and the latch content is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_ad | input | 32 | Multiplexed address/data bus |
| ale | input | 1 | Address-latch-enable, latches open while high |
| ras_n | input | 1 | Row-address strobe, active low |
| trqe_n | input | 1 | Transfer/output-enable strobe, active low |
| qual_en | input | 1 | Enable qualifier for the ROM strobes, active high |
| qual_aux | input | 1 | Extra qualifier for the second ROM-area select, active high |
| rom_oe_n | output | 1 | Program ROM output enable, active low |
| nvram_cs_n | output | 1 | Non-volatile RAM select, active low |
| rom2_cs_n | output | 1 | Second ROM-area select, active low |
| high_cs_n | output | 1 | Top-section select, active low |

## Verification
The decode is exercised with every combination of the eight section codes, the four bit-2/bit-3 pairs and the sixteen settings of the two strobes and two qualifiers, with the latch open; this separates the section match from the sub-word suppression and shows which outputs ignore the strobes and which need each of them. A second pattern closes the latch on chosen addresses and then puts unrelated data on the bus, which tells a held latch from a transparent one. Reset is applied at start and again mid-run, with an open latch, to see the two-edge release and the cleared latch content.

// File: rtl/bus_cs_pkg.sv
package bus_cs_pkg;

  localparam int unsigned BUS_W   = 32;
  localparam int unsigned SECT_W  = 3;
  localparam int unsigned SUB_W   = 2;

  typedef enum logic [SECT_W-1:0] {
    SECT_LOW   = 3'b000,
    SECT_NVRAM = 3'b011,
    SECT_TOP   = 3'b111
  } sect_code_e;

  typedef struct packed {
    logic rom_oe_n;
    logic nvram_cs_n;
    logic rom2_cs_n;
    logic high_cs_n;
  } strobes_t;

  localparam strobes_t STROBES_IDLE = '{rom_oe_n: 1'b1, nvram_cs_n: 1'b1,
                                         rom2_cs_n: 1'b1, high_cs_n: 1'b1};

endpackage

// File: rtl/bus_cs_rst_sync.sv
module bus_cs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/bus_cs_capture.sv
module bus_cs_capture #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] store_d;
  logic             store_en;

  // The register only captures while the gate is open; the output
  // is transparent during that time and shows the stored copy otherwise.
  always_comb begin
    store_en = open_i;
    store_d  = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (store_en) begin
      store_q <= store_d;
    end
  end

  assign q_o = open_i ? d_i : store_q;

  // R2
  closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_i && $past(!open_i)) |-> $stable(q_o));

endmodule

// File: rtl/bus_cs_region.sv
module bus_cs_region
  import bus_cs_pkg::*;
(
  input  logic [SECT_W-1:0] sect_i,
  input  logic [SUB_W-1:0]  sub_i,
  input  logic              active_i,
  input  logic              ras_n_i,
  input  logic              trqe_n_i,
  input  logic              qual_en_i,
  input  logic              qual_aux_i,
  output strobes_t          strobes_o
);

  logic sub_hit;
  logic top_hit;
  logic nv_hit;
  logic cycle_ok;
  logic rom_hit;

  always_comb begin
    sub_hit  = sub_i[0] & ~sub_i[1];
    nv_hit   = (sect_i == SECT_NVRAM);
    top_hit  = (sect_i == SECT_TOP) & ~sub_hit;
    cycle_ok = ~ras_n_i & ~trqe_n_i & qual_en_i;
    rom_hit  = top_hit & cycle_ok;

    strobes_o = STROBES_IDLE;
    if (active_i) begin
      strobes_o.nvram_cs_n = ~nv_hit;
      strobes_o.high_cs_n  = ~top_hit;
      strobes_o.rom_oe_n   = ~rom_hit;
      strobes_o.rom2_cs_n  = ~(rom_hit & qual_aux_i);
    end
  end

endmodule

// File: rtl/bus_cs_decoder.sv
module bus_cs_decoder
  import bus_cs_pkg::*;
#(
  parameter int unsigned ADDR_W    = BUS_W,
  parameter int unsigned SUB_LSB   = 2,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_ad,
  input  logic              ale,
  input  logic              ras_n,
  input  logic              trqe_n,
  input  logic              qual_en,
  input  logic              qual_aux,
  output logic              rom_oe_n,
  output logic              nvram_cs_n,
  output logic              rom2_cs_n,
  output logic              high_cs_n
);

  localparam int unsigned SECT_LSB = ADDR_W - SECT_W;
  localparam int unsigned SUB_MSB  = SUB_LSB + SUB_W - 1;

  logic              rst_sync_n;
  logic [SECT_W-1:0] sect_held;
  logic [SUB_W-1:0]  sub_held;
  strobes_t          strobes;
  logic              unused_bits;

  assign unused_bits = ^{bus_ad[SECT_LSB-1:SUB_MSB+1], bus_ad[SUB_LSB-1:0]};

  bus_cs_rst_sync #(.STAGES(RST_STAGE)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bus_cs_capture #(.WIDTH(SECT_W)) u_sect_cap (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .open_i (ale),
    .d_i    (bus_ad[ADDR_W-1:SECT_LSB]),
    .q_o    (sect_held)
  );

  bus_cs_capture #(.WIDTH(SUB_W)) u_sub_cap (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .open_i (ale),
    .d_i    (bus_ad[SUB_MSB:SUB_LSB]),
    .q_o    (sub_held)
  );

  bus_cs_region u_region (
    .sect_i     (sect_held),
    .sub_i      (sub_held),
    .active_i   (rst_sync_n),
    .ras_n_i    (ras_n),
    .trqe_n_i   (trqe_n),
    .qual_en_i  (qual_en),
    .qual_aux_i (qual_aux),
    .strobes_o  (strobes)
  );

  assign rom_oe_n   = strobes.rom_oe_n;
  assign nvram_cs_n = strobes.nvram_cs_n;
  assign rom2_cs_n  = strobes.rom2_cs_n;
  assign high_cs_n  = strobes.high_cs_n;

  // R6
  trqe_blocks_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trqe_n |-> rom_oe_n);

  // R5
  rom_needs_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> (!ras_n && qual_en && !high_cs_n));

  // R7
  rom2_within_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom2_cs_n |-> (!rom_oe_n && qual_aux));

  // R3
  nv_top_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nvram_cs_n |-> high_cs_n);

  // R9
  release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rom_oe_n && nvram_cs_n && rom2_cs_n && high_cs_n));

endmodule

// File: tb/bus_cs_decoder_bench.sv
module bus_cs_decoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] bus_ad;
  logic        ale, ras_n, trqe_n, qual_en, qual_aux;
  logic        rom_oe_n, nvram_cs_n, rom2_cs_n, high_cs_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // behavioural reference state
  int          rel_edges = 0;
  logic [31:0] held_addr = 32'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cs_decoder u_bus_cs_decoder (
    .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .ale(ale), .ras_n(ras_n),
    .trqe_n(trqe_n), .qual_en(qual_en), .qual_aux(qual_aux),
    .rom_oe_n(rom_oe_n), .nvram_cs_n(nvram_cs_n),
    .rom2_cs_n(rom2_cs_n), .high_cs_n(high_cs_n)
  );

  task automatic check1(input string req, input string name,
                        input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b bus=%h ale=%b t=%0t",
               req, name, act, exp, bus_ad, ale, $time);
    end
  endtask

  task automatic compare(input string phase);
    logic [31:0] view;
    logic [2:0]  sect;
    bit sub, top, nv, rom, rom2, live;
    string rq;
    live = (rst_n === 1'b1) && (rel_edges >= 2);
    view = ale ? bus_ad : held_addr;
    sect = view[31:29];
    sub  = (view[2] == 1'b1) && (view[3] == 1'b0);
    nv   = live && (sect == 3'b011);
    top  = live && (sect == 3'b111) && !sub;
    rom  = top && !ras_n && !trqe_n && qual_en;
    rom2 = rom && qual_aux;
    if (!live) begin
      check1({"R9 ", phase}, "nvram_cs_n", nvram_cs_n, 1'b1);
      check1({"R9 ", phase}, "high_cs_n",  high_cs_n,  1'b1);
      check1({"R9 ", phase}, "rom_oe_n",   rom_oe_n,   1'b1);
      check1({"R9 ", phase}, "rom2_cs_n",  rom2_cs_n,  1'b1);
    end else begin
      rq = (sect != 3'b011 && sect != 3'b111) ? "R8 " : "";
      check1({rq, "R3 ", phase}, "nvram_cs_n", nvram_cs_n, !nv);
      check1({rq, "R4 ", phase}, "high_cs_n",  high_cs_n,  !top);
      check1({rq, trqe_n ? "R6 " : "R5 ", phase}, "rom_oe_n", rom_oe_n, !rom);
      check1({rq, "R7 ", phase}, "rom2_cs_n",  rom2_cs_n,  !rom2);
    end
  endtask

  // one bus cycle: inputs already driven; advance model at edge, compare mid-cycle
  task automatic cycle(input string phase);
    @(posedge clk);
    if (rst_n !== 1'b1) begin
      rel_edges = 0;
      held_addr = 32'h0;
    end else begin
      if (rel_edges >= 2 && ale) held_addr = bus_ad;
      if (rel_edges < 2) rel_edges++;
    end
    @(negedge clk);
    compare(phase);
  endtask

  task automatic drive(input logic [31:0] a, input logic le, input logic [3:0] s);
    bus_ad   = a;
    ale      = le;
    ras_n    = s[0];
    trqe_n   = s[1];
    qual_en  = s[2];
    qual_aux = s[3];
  endtask

  function automatic logic [31:0] mk_addr(input logic [2:0] sect, input logic [1:0] sub);
    logic [31:0] r;
    r = $urandom();
    r[31:29] = sect;
    r[3] = sub[1];
    r[2] = sub[0];
    return r;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    drive(mk_addr(3'b111, 2'b00), 1'b1, 4'b0100);
    #1;
    rel_edges = 0;
    held_addr = 32'h0;
    compare("reset-low");
    cycle("reset-low");
    rst_n = 1'b1;
    cycle("release-edge1");
    cycle("release-edge2");
  endtask

  initial begin
    do_reset();

    // R1 R3 R4 R5 R6 R7 R8: full sweep, latch open
    for (int sc = 0; sc < 8; sc++) begin
      for (int sb = 0; sb < 4; sb++) begin
        for (int st = 0; st < 16; st++) begin
          drive(mk_addr(sc[2:0], sb[1:0]), 1'b1, st[3:0]);
          cycle("R1 open-sweep");
        end
      end
    end

    // R2: close latch on chosen addresses, then put unrelated data on the bus
    for (int k = 0; k < 24; k++) begin
      logic [2:0] sc;
      logic [1:0] sb;
      sc = (k % 3 == 0) ? 3'b011 : ((k % 3 == 1) ? 3'b111 : 3'(k));
      sb = 2'(k >> 2);
      drive(mk_addr(sc, sb), 1'b1, 4'b1100);
      cycle("R1 addr-phase");
      for (int d = 0; d < 6; d++) begin
        drive($urandom(), 1'b0, 4'(d + 8));
        cycle("R2 data-phase");
      end
    end

    // R9: reset mid-run with an open latch pointing at the ROM section
    do_reset();
    drive(32'hFC00_0000, 1'b0, 4'b1100);
    cycle("R9 cleared-latch");
    drive(32'hFFFF_FFF0, 1'b1, 4'b1100);
    cycle("R5 reset-vector");
    drive(32'h0000_0000, 1'b0, 4'b1110);
    cycle("R6 trqe-high");

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule